// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block models a one-bit-wide read-only store that delivers a configuration bitstream to a loading device, one bit per clock. The loader supplies the clock. The ROM keeps an internal address counter and presents the bit at the current address on its serial output. An active-low chip enable and a combined reset/output-enable pin control the block. The polarity of the reset/output-enable pin is fixed by a parameter.

When the last bit has been read, the block stops driving the serial line. It then asserts an active-low cascade output, which enables the next ROM in a daisy chain. Several instances can therefore share one clock and one data line and deliver one long stream. The stored contents are not loaded from a file. They come from a fixed function of the address, so any consumer can predict every bit.

The serial output is a pad pair: a data bit and a drive enable. At the pad, a low enable means high impedance. The loader paces the stream with its clock, so there is no valid/ready handshake and no back-pressure. The loader holds the stream by raising chip enable, which freezes the counter.

Top module: `cfg_serial_rom`

## Requirements
- R1: On each rising clock edge where chip enable is low, the reset function is inactive and the read is not complete, the address advances by one.
- R2: While the reset function is active, the address is held at zero, the read-complete state is cleared, `data_oe` is 0 and `cascade_n` is 1. This takes effect at once, without waiting for a clock edge.
- R3: With `RST_ACTIVE_HIGH`=1, a high `rst_oe` resets the block and a low `rst_oe` enables output. With `RST_ACTIVE_HIGH`=0, the meanings are swapped.
- R4: While `ce_n` is high, the address does not change and `data_oe` is 0.
- R5: While `data_oe` is 1, `data_o` equals the content bit of the current address. After reset, the first bit shown is the bit at address 0.
- R6: The content bit for address a is computed in three steps. First, s = a[15:0] XOR `SEED`. Second, f = s[15]^s[13]^s[12]^s[10]. Third, the bit is s[14]^f.
- R7: The clock edge that advances past address `DEPTH`-1 marks the read complete. After that, the address never wraps, `data_oe` stays 0 and the state persists until reset.
- R8: `cascade_n` is 0 exactly when the read is complete, `ce_n` is low and the reset function is inactive. Otherwise `cascade_n` follows `ce_n` high. Any activation of the reset function clears the complete state, so `cascade_n` then stays 1 until a new full read.
- R9: In a chain, the first device's `cascade_n` drives the second device's `ce_n`, and the two share clock and data line. The chain then delivers all bits of the first device followed by all bits of the second. At no time do both devices drive the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock from the loader; rising edge advances the address |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset / output enable, polarity set by `RST_ACTIVE_HIGH` |
| data_o | output | 1 | Serial content bit |
| data_oe | output | 1 | Drive enable for `data_o`; 0 means high impedance at the pad |
| cascade_n | output | 1 | Active-low enable for the next device in the chain |

## Verification
The clocked assertions assume that `rst_oe` and `ce_n` change only away from the rising clock edge. They also assume that a reset pulse lasts long enough to be seen at an edge. The bench meets both assumptions by driving every input on the falling edge and holding each reset for at least one full cycle. The assertions are disabled while the reset function is active, because the asynchronous clear would otherwise break their next-cycle relations. Random phases mix enable gaps and rare resets, so that the stream is interrupted before, at and after the last address.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  // Content bit derived from one feedback step on an address-seeded word.
  function automatic logic content_bit(input logic [15:0] addr, input logic [15:0] seed);
    logic [15:0] s;
    logic        fb;
    s  = addr ^ seed;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return s[14] ^ fb;
  endfunction
endpackage

// File: rtl/cfgrom_addr_ctr.sv
module cfgrom_addr_ctr #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_a,
  input  logic          step_en,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          done_q;

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (step_en && !done_q) begin
      if (addr_q == LAST) done_q <= 1'b1;
      else                addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

  // R1: an enabled step below the last address moves by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (rst_a)
    (step_en && !done_q && addr_q != LAST) |=> (addr_q == $past(addr_q) + AW'(1)));
  // R4: no step, no movement
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst_a)
    !step_en |=> $stable(addr_q));
  // R7: completion is sticky and the address never wraps
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst_a)
    done_q |=> (done_q && $stable(addr_q)));
  // R7: completion only follows the last address
  a_r7_at_last: assert property (@(posedge clk) disable iff (rst_a)
    $rose(done_q) |-> (addr_q == LAST));
endmodule

// File: rtl/cfgrom_pattern.sv
module cfgrom_pattern #(
  parameter int          AW   = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);
  import cfgrom_pkg::*;
  logic [15:0] addr16;
  always_comb begin
    addr16 = '0;
    for (int i = 0; i < AW && i < 16; i++) addr16[i] = addr_i[i];
    bit_o = content_bit(addr16, SEED);
  end
endmodule

// File: rtl/cfgrom_port_ctl.sv
module cfgrom_port_ctl (
  input  logic ce_act,
  input  logic oe_act,
  input  logic done,
  input  logic bit_i,
  output logic step_en,
  output logic data_o,
  output logic data_oe,
  output logic cascade_n
);
  always_comb begin
    step_en   = ce_act && oe_act;
    data_oe   = ce_act && oe_act && !done;
    data_o    = data_oe ? bit_i : 1'b0;
    cascade_n = !(ce_act && oe_act && done);
  end
endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom #(
  parameter int          DEPTH           = 256,
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  parameter logic [15:0] SEED            = 16'hACE1
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data_o,
  output logic data_oe,
  output logic cascade_n
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic          rst_act;
  logic          step_en;
  logic          done;
  logic          cur_bit;
  logic [AW-1:0] addr;

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_hi
      assign rst_act = rst_oe;
    end else begin : g_rst_lo
      assign rst_act = ~rst_oe;
    end
  endgenerate

  cfgrom_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk(clk), .rst_a(rst_act), .step_en(step_en), .addr_o(addr), .done_o(done)
  );

  cfgrom_pattern #(.AW(AW), .SEED(SEED)) u_pat (
    .addr_i(addr), .bit_o(cur_bit)
  );

  cfgrom_port_ctl u_ctl (
    .ce_act(~ce_n), .oe_act(~rst_act), .done(done), .bit_i(cur_bit),
    .step_en(step_en), .data_o(data_o), .data_oe(data_oe), .cascade_n(cascade_n)
  );

  // R8: the next device is never enabled while this one drives the line
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst_act)
    !cascade_n |-> !data_oe);
  // R4: a disabled device does not drive
  a_r4_no_drive: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |-> (!data_oe && cascade_n));
  // R7: once the line is released after a full read it stays released
  a_r7_release: assert property (@(posedge clk) disable iff (rst_act)
    (!ce_n && !data_oe && $past(!ce_n && !data_oe)) |=> (ce_n || !data_oe));
endmodule

// File: tb/sim_cfg_serial_rom.sv
`timescale 1ns/100ps
module sim_cfg_serial_rom;
  localparam int D0 = 64;
  localparam int D1 = 24;
  localparam int D2 = 40;
  localparam logic [15:0] S0 = 16'hACE1;
  localparam logic [15:0] S2 = 16'h1234;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  function automatic logic ref_bit(input int a, input logic [15:0] seed);
    logic [15:0] s;
    logic f;
    s = 16'(a) ^ seed;
    f = s[15] ^ s[13] ^ s[12] ^ s[10];
    return s[14] ^ f;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // single device, active-high reset
  logic ce0 = 1'b1, rst0 = 1'b1;
  logic d0, oe0, cn0;
  cfg_serial_rom #(.DEPTH(D0), .RST_ACTIVE_HIGH(1'b1), .SEED(S0)) u0 (
    .clk(clk), .ce_n(ce0), .rst_oe(rst0), .data_o(d0), .data_oe(oe0), .cascade_n(cn0));

  // chain, active-low reset
  logic ce1 = 1'b1, rstn = 1'b0;
  logic d1, oe1, cn1, d2, oe2, cn2, line;
  cfg_serial_rom #(.DEPTH(D1), .RST_ACTIVE_HIGH(1'b0), .SEED(S0)) u1 (
    .clk(clk), .ce_n(ce1), .rst_oe(rstn), .data_o(d1), .data_oe(oe1), .cascade_n(cn1));
  cfg_serial_rom #(.DEPTH(D2), .RST_ACTIVE_HIGH(1'b0), .SEED(S2)) u2 (
    .clk(clk), .ce_n(cn1), .rst_oe(rstn), .data_o(d2), .data_oe(oe2), .cascade_n(cn2));
  assign line = oe1 ? d1 : (oe2 ? d2 : 1'b0);

  int  m_addr = 0;
  bit  m_done = 1'b0;

  task automatic cyc0(input logic ce, input logic rs);
    @(negedge clk);
    ce0 = ce; rst0 = rs;
    @(posedge clk);
    if (rs) begin m_addr = 0; m_done = 1'b0; end
    else if (!ce && !m_done) begin
      if (m_addr == D0 - 1) m_done = 1'b1; else m_addr++;
    end
    #1;
    chk(oe0, !ce && !rs && !m_done, "R1/R4/R7 data_oe");
    chk(cn0, !(m_done && !ce && !rs), "R8 cascade_n");
    if (!ce && !rs && !m_done) chk(d0, ref_bit(m_addr, S0), "R5/R6 data_o");
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    // R2/R3: reset state, active-high polarity
    #1;
    chk(oe0, 1'b0, "R2 oe in reset");
    chk(cn0, 1'b1, "R2 cascade in reset");
    cyc0(1'b0, 1'b1);
    // R5: first bit after release is address 0
    @(negedge clk); rst0 = 1'b0; ce0 = 1'b0; #1;
    chk(oe0, 1'b1, "R3 high-polarity release drives");
    chk(d0, ref_bit(0, S0), "R5 first bit");
    @(negedge clk); rst0 = 1'b1; #0.5; rst0 = 1'b1;
    // directed full read and past end (R1, R7, R8)
    for (int i = 0; i < D0 + 6; i++) cyc0(1'b0, 1'b0);
    chk(cn0, 1'b0, "R8 cascade after full read");
    cyc0(1'b1, 1'b0);
    chk(cn0, 1'b1, "R8 cascade follows ce_n high");
    cyc0(1'b0, 1'b0);
    chk(cn0, 1'b0, "R8 cascade follows ce_n low");
    cyc0(1'b0, 1'b1);
    chk(cn0, 1'b1, "R2 cascade cleared by reset");
    // R4: enable gaps mid-stream
    for (int i = 0; i < 10; i++) cyc0(i[0], 1'b0);
    // random phase
    for (int i = 0; i < 3000; i++)
      cyc0(($urandom % 5) == 0, ($urandom % 150) == 0);

    // chain with active-low reset (R3, R9)
    @(negedge clk); ce1 = 1'b0; #1;
    chk(oe1, 1'b0, "R3 low-polarity reset holds off");
    chk(cn2, 1'b1, "R2 chain cascade in reset");
    @(negedge clk); rstn = 1'b1;
    for (int k = 0; k < D1 + D2; k++) begin
      #1;
      chk(oe1 & oe2, 1'b0, "R9 single driver");
      chk(oe1 | oe2, 1'b1, "R9 line driven");
      chk(line, (k < D1) ? ref_bit(k, S0) : ref_bit(k - D1, S2), "R9 chain stream");
      @(negedge clk);
    end
    #1;
    chk(oe1 | oe2, 1'b0, "R7 chain released");
    chk(cn2, 1'b0, "R9 chain end cascade");
    @(negedge clk); ce1 = 1'b1; #1;
    chk(cn1, 1'b1, "R8 first cascade follows ce_n");
    chk(cn2, 1'b1, "R8 second cascade follows upstream");
    @(negedge clk); ce1 = 1'b0; rstn = 1'b0; #1;
    chk(cn1, 1'b1, "R2 async reset clears cascade");
    chk(oe1, 1'b0, "R2 async reset no drive");
    @(negedge clk); rstn = 1'b1; #1;
    chk(oe1, 1'b1, "R2 restart drives");
    chk(line, ref_bit(0, S0), "R2 restart at address 0");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule